// File: doc/BRIEF.md
# Host Bus Data Buffer with Handshake Flags

This block is the host-facing side of a small peripheral microcontroller. An external host sees one byte-wide register pair behind a chip select, a read strobe, a write strobe and one address bit. It writes commands or data into an input buffer, reads results from an output buffer, and polls a status byte to learn when each buffer is ready. The local CPU core sits on the other side. It drains the input buffer, fills the output buffer, sets or clears one of its own flags, and writes a four-bit user field into the upper half of the status byte.

The host strobes are asynchronous to the core clock. The byte on the bus is captured on the rising edge of the write strobe. The edges that complete an access pass through a synchroniser, and only then do they update the handshake flags in the core clock domain. If a host event and a CPU action hit the same flag in the same cycle, the host event wins.

Three of the upper port pins can be switched, under a CPU-written enable register, from ordinary port outputs to handshake outputs. Two of them are interrupt lines that show output-buffer-full and the inverse of input-buffer-full. The third is a transfer request. A fourth pin is an active-low transfer acknowledge input. While it is low, host strobes reach the data buffers without chip select, and the access clears the request.

Top module: `hostbus_buffer`

## Requirements
- R1: After reset, the status byte, both buffers, the enable register and the transfer request are all 0. `bus_oe` is 0, and `port_hi_out` equals `port_hi_in`.
- R2: A host write with `host_sel_n` low does three things within 3 clock cycles after `host_wr_n` rises: it stores the byte in the input buffer, sets IBF, and sets F1 equal to `host_addr`.
- R3: The status byte has OBF in bit 0, IBF in bit 1, F0 in bit 2, F1 in bit 3 and the user field in bits 7:4. A host read with `host_addr`=1 returns this byte and changes no flag.
- R4: A host read with `host_addr`=0 returns the output buffer. OBF clears within 3 cycles after `host_rd_n` rises.
- R5: A CPU pulse on `cpu_ibuf_rd` clears IBF on the next edge. A pulse on `cpu_obuf_wr` loads `cpu_wdata` into the output buffer and sets OBF.
- R6: Only the CPU changes F0: `cpu_f0_set` sets it and `cpu_f0_clr` clears it. `cpu_usr_wr` loads `cpu_wdata[7:4]` into the user field.
- R7: If a host write completes in the same cycle as `cpu_ibuf_rd`, IBF ends up 1. If a host data read completes in the same cycle as `cpu_obuf_wr`, OBF ends up 0 and the buffer still takes the new byte.
- R8: `bus_oe` is 1 only while `host_rd_n` is low and either `host_sel_n` is low or the transfer path is active. A strobe with neither of these changes no buffer or flag.
- R9: `cpu_en_wr` loads the enable register from `cpu_wdata`: bit 0 enables the interrupt lines and bit 1 enables the transfer path. With bit 0 set, `port_hi_out[0]` shows OBF and `port_hi_out[1]` shows the inverse of IBF. Otherwise these pins follow `port_hi_in`.
- R10: `cpu_drq_set` sets the transfer request, which is shown on `port_hi_out[2]` when bit 1 is enabled. With bit 1 enabled and `dma_ack_n` low, a read or write accesses the data buffers as if `host_addr` were 0, with F1 cleared on a write, and the access clears the request.
- R11: The written byte is the one on `host_din` at the rising edge of `host_wr_n`. Later changes of the bus do not alter the input buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 1 | Host address bit: 1 selects status or command, 0 selects data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| bus_oe | output | 1 | Drive enable for the host data bus |
| cpu_ibuf_rd | input | 1 | CPU consumes the input buffer |
| cpu_obuf_wr | input | 1 | CPU loads the output buffer |
| cpu_f0_set | input | 1 | CPU sets F0 |
| cpu_f0_clr | input | 1 | CPU clears F0 |
| cpu_usr_wr | input | 1 | CPU writes the user status field |
| cpu_en_wr | input | 1 | CPU writes the pin-function enable register |
| cpu_drq_set | input | 1 | CPU raises the transfer request |
| cpu_wdata | input | 8 | CPU write data for the buffer, field and enables |
| cpu_ibuf | output | 8 | Input buffer contents seen by the CPU |
| cpu_status | output | 8 | Status byte seen by the CPU |
| dma_ack_n | input | 1 | Transfer acknowledge, active low |
| port_hi_in | input | 3 | Ordinary port values for pins 4 to 6 |
| port_hi_out | output | 3 | Driven values of pins 4 to 6 |

## Verification
The bench aims at the same-cycle collisions between a host event and a CPU action on one flag. A design that gave the CPU priority would either lose a freshly written byte's IBF or leave OBF set after the host has taken the byte. It changes the host bus after the write strobe rises while chip select is still low, which catches a design that samples data late. It also pulses strobes with no select, which catches a decoder that ignores chip select. The transfer sequence moves four bytes each way with `host_addr` held at 1. A design that still decoded the address under acknowledge would return the status byte, or set F1, instead of moving data.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

  localparam int DW      = 8;
  localparam int USR_LSB = 4;
  localparam int USR_W   = DW - USR_LSB;
  localparam int HI_PINS = 3;

  // enable register bit positions
  localparam int EN_IRQ = 0;
  localparam int EN_XFR = 1;

  // packed so that obf is bit 0, ibf bit 1, f0 bit 2, f1 bit 3
  typedef struct packed {
    logic [USR_W-1:0] usr;
    logic             f1;
    logic             f0;
    logic             ibf;
    logic             obf;
  } status_t;

  function automatic logic [DW-1:0] pack_status(status_t s);
    return DW'(s);
  endfunction

  // host-side update beats CPU-side update, else hold
  function automatic logic resolve_flag(logic cur, logic host_ev, logic host_val,
                                        logic cpu_ev, logic cpu_val);
    if (host_ev)     return host_val;
    else if (cpu_ev) return cpu_val;
    else             return cur;
  endfunction

endpackage

// File: rtl/hbb_strobe_sync.sv
module hbb_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic release_pulse
);

  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= strobe_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], strobe_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b1;
    else        last <= chain[STAGES-1];
  end

  assign release_pulse = chain[STAGES-1] & ~last;

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> !release_pulse);

endmodule

// File: rtl/hbb_flags.sv
module hbb_flags
  import hbb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_evt,
  input  logic [DW-1:0] host_wr_byte,
  input  logic          host_wr_a0,
  input  logic          host_rd_evt,
  input  logic          cpu_ibuf_rd,
  input  logic          cpu_obuf_wr,
  input  logic          cpu_f0_set,
  input  logic          cpu_f0_clr,
  input  logic          cpu_usr_wr,
  input  logic [DW-1:0] cpu_wdata,
  output status_t       stat,
  output logic [DW-1:0] ibuf,
  output logic [DW-1:0] obuf
);

  status_t stat_nx;

  always_comb begin
    stat_nx     = stat;
    stat_nx.ibf = resolve_flag(stat.ibf, host_wr_evt, 1'b1, cpu_ibuf_rd, 1'b0);
    stat_nx.obf = resolve_flag(stat.obf, host_rd_evt, 1'b0, cpu_obuf_wr, 1'b1);
    stat_nx.f1  = resolve_flag(stat.f1,  host_wr_evt, host_wr_a0, 1'b0, 1'b0);
    stat_nx.f0  = resolve_flag(stat.f0,  1'b0, 1'b0, cpu_f0_set | cpu_f0_clr, cpu_f0_set);
    if (cpu_usr_wr) stat_nx.usr = cpu_wdata[DW-1:USR_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      ibuf <= '0;
      obuf <= '0;
    end else begin
      stat <= stat_nx;
      if (host_wr_evt) ibuf <= host_wr_byte;
      if (cpu_obuf_wr) obuf <= cpu_wdata;
    end
  end

  p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_evt |=> stat.ibf);
  p_f1_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_evt |=> stat.f1 == $past(host_wr_a0));
  p_obf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_evt |=> !stat.obf);
  p_ibf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ibuf_rd && !host_wr_evt |=> !stat.ibf);
  p_obf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_obuf_wr && !host_rd_evt |=> stat.obf && obuf == $past(cpu_wdata));
  p_f0_cpu_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_f0_set && !cpu_f0_clr |=> $stable(stat.f0));
  p_host_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_evt && cpu_obuf_wr |=> !stat.obf);

endmodule

// File: rtl/hbb_port2.sv
module hbb_port2
  import hbb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_en_wr,
  input  logic [1:0]         cpu_en_val,
  input  logic               cpu_drq_set,
  input  logic               xfr_evt,
  input  logic               obf,
  input  logic               ibf,
  input  logic               dma_ack_n,
  input  logic [HI_PINS-1:0] port_hi_in,
  output logic [HI_PINS-1:0] port_hi_out,
  output logic               xfr_sel
);

  logic irq_en, xfr_en, drq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      xfr_en <= 1'b0;
      drq    <= 1'b0;
    end else begin
      if (cpu_en_wr) begin
        irq_en <= cpu_en_val[EN_IRQ];
        xfr_en <= cpu_en_val[EN_XFR];
      end
      drq <= resolve_flag(drq, xfr_evt, 1'b0, cpu_drq_set, 1'b1);
    end
  end

  assign xfr_sel = xfr_en & ~dma_ack_n;

  always_comb begin
    port_hi_out = port_hi_in;
    if (irq_en) begin
      port_hi_out[0] = obf;
      port_hi_out[1] = ~ibf;
    end
    if (xfr_en) port_hi_out[2] = drq;
  end

  p_drq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfr_evt |=> !drq);
  p_drq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_drq_set && !xfr_evt |=> drq);
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en && $fell(port_hi_out[1]) |-> ibf);

endmodule

// File: rtl/hostbus_buffer.sv
module hostbus_buffer
  import hbb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel_n,
  input  logic               host_rd_n,
  input  logic               host_wr_n,
  input  logic               host_addr,
  input  logic [DW-1:0]      host_din,
  output logic [DW-1:0]      host_dout,
  output logic               bus_oe,
  input  logic               cpu_ibuf_rd,
  input  logic               cpu_obuf_wr,
  input  logic               cpu_f0_set,
  input  logic               cpu_f0_clr,
  input  logic               cpu_usr_wr,
  input  logic               cpu_en_wr,
  input  logic               cpu_drq_set,
  input  logic [DW-1:0]      cpu_wdata,
  output logic [DW-1:0]      cpu_ibuf,
  output logic [DW-1:0]      cpu_status,
  input  logic               dma_ack_n,
  input  logic [HI_PINS-1:0] port_hi_in,
  output logic [HI_PINS-1:0] port_hi_out
);

  // named internal events
  logic          xfr_sel;
  logic          wr_release, rd_release;
  logic          wr_hit, wr_a0, wr_xfr;
  logic [DW-1:0] wr_byte;
  logic          rd_data_hit, rd_xfr;
  logic          host_wr_evt, host_rd_evt, xfr_evt;
  status_t       stat;
  logic [DW-1:0] obuf;

  // byte and access kind captured on the releasing strobe edge
  always_ff @(posedge host_wr_n or negedge rst_n) begin
    if (!rst_n) begin
      wr_hit  <= 1'b0;
      wr_a0   <= 1'b0;
      wr_xfr  <= 1'b0;
      wr_byte <= '0;
    end else begin
      wr_hit  <= ~host_sel_n | xfr_sel;
      wr_a0   <= host_addr & ~xfr_sel;
      wr_xfr  <= xfr_sel;
      wr_byte <= host_din;
    end
  end

  always_ff @(posedge host_rd_n or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_hit <= 1'b0;
      rd_xfr      <= 1'b0;
    end else begin
      rd_data_hit <= xfr_sel | (~host_sel_n & ~host_addr);
      rd_xfr      <= xfr_sel;
    end
  end

  hbb_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n), .release_pulse(wr_release)
  );
  hbb_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_rd_n), .release_pulse(rd_release)
  );

  assign host_wr_evt = wr_release & wr_hit;
  assign host_rd_evt = rd_release & rd_data_hit;
  assign xfr_evt     = (wr_release & wr_xfr) | (rd_release & rd_xfr);

  hbb_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .host_wr_evt(host_wr_evt), .host_wr_byte(wr_byte), .host_wr_a0(wr_a0),
    .host_rd_evt(host_rd_evt),
    .cpu_ibuf_rd(cpu_ibuf_rd), .cpu_obuf_wr(cpu_obuf_wr),
    .cpu_f0_set(cpu_f0_set), .cpu_f0_clr(cpu_f0_clr),
    .cpu_usr_wr(cpu_usr_wr), .cpu_wdata(cpu_wdata),
    .stat(stat), .ibuf(cpu_ibuf), .obuf(obuf)
  );

  hbb_port2 u_port2 (
    .clk(clk), .rst_n(rst_n),
    .cpu_en_wr(cpu_en_wr), .cpu_en_val(cpu_wdata[1:0]),
    .cpu_drq_set(cpu_drq_set), .xfr_evt(xfr_evt),
    .obf(stat.obf), .ibf(stat.ibf), .dma_ack_n(dma_ack_n),
    .port_hi_in(port_hi_in), .port_hi_out(port_hi_out), .xfr_sel(xfr_sel)
  );

  assign cpu_status = pack_status(stat);
  assign bus_oe     = ~host_rd_n & (~host_sel_n | xfr_sel);
  assign host_dout  = (xfr_sel | ~host_addr) ? obuf : cpu_status;

  p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_n |-> !bus_oe);
  p_no_evt_unselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |-> !host_wr_evt);

endmodule

// File: tb/hostbus_buffer_test.sv
`timescale 1ns/1ps
module hostbus_buffer_test;

  logic       clk = 0, rst_n = 0;
  logic       sel_n = 1, rd_n = 1, wr_n = 1, addr = 0;
  logic [7:0] din = 0, wdata = 0;
  logic       ibuf_rd = 0, obuf_wr = 0, f0_set = 0, f0_clr = 0, usr_wr = 0, en_wr = 0, drq_set = 0;
  logic       ack_n = 1;
  logic [2:0] hi_in = 3'b010;
  wire  [7:0] dout, ibuf, status;
  wire        oe;
  wire  [2:0] hi_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic       m_ibf = 0, m_obf = 0, m_f0 = 0, m_f1 = 0, m_irq = 0, m_xfr = 0, m_drq = 0;
  logic [3:0] m_usr = 0;
  logic [7:0] m_ibuf = 0, m_obuf = 0;

  always #4 clk = ~clk;

  hostbus_buffer uut (
    .clk(clk), .rst_n(rst_n), .host_sel_n(sel_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
    .host_addr(addr), .host_din(din), .host_dout(dout), .bus_oe(oe),
    .cpu_ibuf_rd(ibuf_rd), .cpu_obuf_wr(obuf_wr), .cpu_f0_set(f0_set), .cpu_f0_clr(f0_clr),
    .cpu_usr_wr(usr_wr), .cpu_en_wr(en_wr), .cpu_drq_set(drq_set), .cpu_wdata(wdata),
    .cpu_ibuf(ibuf), .cpu_status(status), .dma_ack_n(ack_n),
    .port_hi_in(hi_in), .port_hi_out(hi_out)
  );

  function automatic logic [7:0] exp_status();
    return {m_usr, m_f1, m_f0, m_ibf, m_obf};
  endfunction

  function automatic logic [2:0] exp_pins();
    logic [2:0] p = hi_in;
    if (m_irq) begin p[0] = m_obf; p[1] = !m_ibf; end
    if (m_xfr) p[2] = m_drq;
    return p;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check({tag, " status"}, status, exp_status());
    check({tag, " ibuf"}, ibuf, m_ibuf);
    check({tag, " pins R9"}, {5'b0, hi_out}, {5'b0, exp_pins()});
  endtask

  // mode 0 chip select, 1 acknowledge, 2 no select
  task automatic host_write(input int mode, input logic [7:0] d, input logic a);
    @(negedge clk); addr = a;
    if (mode == 0) sel_n = 0;
    if (mode == 1) ack_n = 0;
    @(negedge clk); wr_n = 0; din = d;
    @(negedge clk);
    @(negedge clk); wr_n = 1;
    @(negedge clk); din = ~d; // R11: late bus change
    @(negedge clk); sel_n = 1; ack_n = 1;
    repeat (4) @(negedge clk);
    if (mode == 0 || (mode == 1 && m_xfr)) begin
      m_ibf = 1; m_ibuf = d; m_f1 = (mode == 0) ? a : 1'b0;
      if (mode == 1) m_drq = 0;
    end
  endtask

  task automatic host_read(input int mode, input logic a, output logic [7:0] d, output logic o);
    @(negedge clk); addr = a;
    if (mode == 0) sel_n = 0;
    if (mode == 1) ack_n = 0;
    @(negedge clk); rd_n = 0;
    @(negedge clk); d = dout; o = oe;
    @(negedge clk); rd_n = 1;
    @(negedge clk); sel_n = 1; ack_n = 1;
    repeat (4) @(negedge clk);
    if ((mode == 0 && !a) || (mode == 1 && m_xfr)) begin
      m_obf = 0;
      if (mode == 1) m_drq = 0;
    end
  endtask

  // 0 ibuf read, 1 obuf load, 2 f0 set, 3 f0 clr, 4 user field, 5 enables, 6 request
  task automatic cpu_op(input int op, input logic [7:0] d);
    @(negedge clk); wdata = d;
    case (op)
      0: ibuf_rd = 1;
      1: obuf_wr = 1;
      2: f0_set = 1;
      3: f0_clr = 1;
      4: usr_wr = 1;
      5: en_wr = 1;
      default: drq_set = 1;
    endcase
    @(negedge clk);
    {ibuf_rd, obuf_wr, f0_set, f0_clr, usr_wr, en_wr, drq_set} = '0;
    case (op)
      0: m_ibf = 0;
      1: begin m_obuf = d; m_obf = 1; end
      2: m_f0 = 1;
      3: m_f0 = 0;
      4: m_usr = d[7:4];
      5: begin m_irq = d[0]; m_xfr = d[1]; end
      default: m_drq = 1;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    logic       ro;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 ibuf", ibuf, 8'h00);
    check("R1 oe", {7'b0, oe}, 8'h00);
    check("R1 pins", {5'b0, hi_out}, {5'b0, hi_in});

    // echo exchange
    host_write(0, 8'h55, 1'b0);
    check_state("R2 echo write");
    cpu_op(0, 8'h00);
    cpu_op(1, 8'hAA);
    host_read(0, 1'b1, rb, ro);
    check("R3 status read", rb, exp_status());
    check("R8 oe selected", {7'b0, ro}, 8'h01);
    host_read(0, 1'b0, rb, ro);
    check("R4 data read", rb, 8'hAA);
    check_state("R4 obf cleared");

    // flag combinations
    host_write(0, 8'h02, 1'b1);
    check_state("R2 f1 set");
    host_write(0, 8'h02, 1'b0);
    check_state("R2 f1 cleared");
    cpu_op(2, 0);
    check_state("R6 f0 set");
    cpu_op(4, 8'hA0);
    host_read(0, 1'b1, rb, ro);
    check("R3 R6 user field", rb, exp_status());
    check_state("R3 read quiet");
    cpu_op(3, 0);
    cpu_op(4, 8'h50);
    check_state("R6 f0 clr field 5");

    // unselected strobes
    host_write(2, 8'hEE, 1'b1);
    check_state("R8 unselected write");
    host_read(2, 1'b0, rb, ro);
    check("R8 unselected oe", {7'b0, ro}, 8'h00);

    // R7 collision: host write vs CPU consume
    @(negedge clk); sel_n = 0; addr = 0;
    @(negedge clk); wr_n = 0; din = 8'h3C;
    @(negedge clk); wr_n = 1;
    @(negedge clk);
    @(negedge clk); ibuf_rd = 1;
    @(negedge clk); ibuf_rd = 0; sel_n = 1;
    repeat (3) @(negedge clk);
    m_ibf = 1; m_ibuf = 8'h3C; m_f1 = 0;
    check_state("R7 ibf host wins");

    // R7 collision: host data read vs CPU load
    cpu_op(1, 8'h11);
    @(negedge clk); sel_n = 0; addr = 0;
    @(negedge clk); rd_n = 0;
    @(negedge clk); rd_n = 1;
    @(negedge clk);
    @(negedge clk); obuf_wr = 1; wdata = 8'h22;
    @(negedge clk); obuf_wr = 0; sel_n = 1;
    repeat (3) @(negedge clk);
    m_obf = 0; m_obuf = 8'h22;
    check_state("R7 obf host wins");
    host_read(0, 1'b0, rb, ro);
    check("R7 new byte kept", rb, 8'h22);

    // constrained random
    for (int i = 0; i < 80; i++) begin
      int op = $urandom_range(0, 6);
      logic [7:0] d = 8'($urandom);
      logic       a = 1'($urandom);
      case (op)
        0: host_write(0, d, a);
        1: begin
             logic [7:0] e = exp_status();
             host_read(0, 1'b1, rb, ro);
             check("R3 random status", rb, e);
           end
        2: begin
             logic [7:0] e = m_obuf;
             host_read(0, 1'b0, rb, ro);
             check("R4 random data", rb, e);
           end
        3: cpu_op(0, d);
        4: cpu_op(1, d);
        5: cpu_op(a ? 2 : 3, d);
        default: cpu_op(4, d);
      endcase
      check_state("R5 random");
    end
    cpu_op(0, 0);
    if (m_obf) host_read(0, 1'b0, rb, ro);

    // interrupt lines
    cpu_op(5, 8'h01);
    check_state("R9 enabled idle");
    host_write(0, 8'h04, 1'b1);
    check("R9 ibf line low", {7'b0, hi_out[1]}, 8'h00);
    cpu_op(0, 0);
    check("R9 ibf line high", {7'b0, hi_out[1]}, 8'h01);
    cpu_op(1, 8'h40);
    check("R9 obf line high", {7'b0, hi_out[0]}, 8'h01);
    host_read(0, 1'b0, rb, ro);
    check("R9 obf line low", {7'b0, hi_out[0]}, 8'h00);
    cpu_op(5, 8'h00);
    check("R9 disabled pins", {5'b0, hi_out}, {5'b0, hi_in});

    // acknowledge ignored while transfer disabled
    cpu_op(1, 8'h77);
    host_read(1, 1'b1, rb, ro);
    check("R10 ack ignored oe", {7'b0, ro}, 8'h00);
    host_read(0, 1'b0, rb, ro);

    // transfers
    cpu_op(5, 8'h02);
    for (int n = 4; n >= 1; n--) begin
      cpu_op(1, 8'(n));
      cpu_op(6, 0);
      check("R10 request raised", {7'b0, hi_out[2]}, 8'h01);
      host_read(0, 1'b1, rb, ro);
      check("R10 status before read", rb, exp_status());
      host_read(1, 1'b1, rb, ro);
      check("R10 xfer read data", rb, 8'(n));
      check("R10 xfer read oe", {7'b0, ro}, 8'h01);
      check_state("R10 after xfer read");
    end
    for (int n = 4; n >= 1; n--) begin
      cpu_op(6, 0);
      check("R10 request raised w", {7'b0, hi_out[2]}, 8'h01);
      host_write(1, 8'(n), 1'b1);
      check_state("R10 after xfer write");
      cpu_op(0, 0);
    end
    check_state("R10 done");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule